// File: doc/BRIEF.md
# Credit-Flow Ring Router Node

This block is one node of a bidirectional on-chip ring. It has a link to its left neighbour, a link to its right neighbour and a local port. Each ring input lands in a small two-entry buffer. A flit that arrives from the left keeps travelling rightwards, and one that arrives from the right keeps travelling leftwards, until it reaches the node whose identifier matches its destination field. That node hands the flit to its local eject port. Backpressure between neighbours is credit based. Each output counts the free slots in the neighbour's buffer, and each buffer pulses a credit back upstream in the cycle a flit leaves it.

Flits already on the ring always win an output over a local injection. The local source can still inject in any cycle in which the chosen direction has a credit and no through flit competes for it, so it never waits for a reserved slot. Both ring directions may deliver to this node in the same cycle. A round-robin ejection arbiter picks between them so that neither direction starves. When nothing is blocked, a flit crosses the node in one cycle.

A flit is `ID_W + DATA_W` bits wide. The destination node identifier sits in the top `ID_W` bits and the payload in the low `DATA_W` bits. With the default parameters, bits [10:8] are the destination and bits [7:0] are the payload.

Top module: `ring_credit_router`

## Requirements
- R1: Each ring input has a two-entry buffer. The credit output toward that neighbour is high for exactly the cycles in which a flit leaves the buffer, whether it is forwarded or ejected.
- R2: Each ring output has a credit count that resets to 2, falls by one per flit sent and rises by one per credit received. The count stays within 0..2, and no flit is sent while it is 0.
- R3: A flit on a ring input that is not for this node appears on the opposite ring output in the next cycle, provided that output has a credit. A flit from the left input goes out on the right output, and a flit from the right input goes out on the left output.
- R4: A flit whose destination bits [10:8] equal NODE_ID (default 2) goes to the eject port with its bits unchanged and is not forwarded.
- R5: A local injection is refused (inj_rdy_o low) while the buffered head flit of the ring input that feeds the chosen output is a through flit. This holds even when that flit is itself stalled for lack of credit.
- R6: An injection is accepted in any cycle in which the chosen output has a credit and no through flit competes for it. inj_dir_i = 0 selects the right output and inj_dir_i = 1 selects the left output. The flit appears on that output in the same cycle.
- R7: When both input buffers hold a flit for this node, the ejection arbiter alternates between them. The left input wins first after reset.
- R8: A through flit stalled by a zero credit count stays at the head of its buffer and leaves in the cycle after a credit returns. Across a stream, no flit is lost or duplicated and the order is kept.
- R9: After reset, all output valids and credit outputs are low and inj_rdy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lft_in_vld_i | input | 1 | Flit valid from left neighbour |
| lft_in_flit_i | input | ID_W+DATA_W | Flit from left neighbour |
| lft_crd_o | output | 1 | Credit returned to left neighbour |
| lft_out_vld_o | output | 1 | Flit valid toward left neighbour |
| lft_out_flit_o | output | ID_W+DATA_W | Flit toward left neighbour |
| lft_crd_i | input | 1 | Credit from left neighbour |
| rgt_in_vld_i | input | 1 | Flit valid from right neighbour |
| rgt_in_flit_i | input | ID_W+DATA_W | Flit from right neighbour |
| rgt_crd_o | output | 1 | Credit returned to right neighbour |
| rgt_out_vld_o | output | 1 | Flit valid toward right neighbour |
| rgt_out_flit_o | output | ID_W+DATA_W | Flit toward right neighbour |
| rgt_crd_i | input | 1 | Credit from right neighbour |
| inj_vld_i | input | 1 | Local injection request |
| inj_dir_i | input | 1 | Injection direction, 0 right, 1 left |
| inj_flit_i | input | ID_W+DATA_W | Local flit to inject |
| inj_rdy_o | output | 1 | Injection accepted this cycle |
| ej_vld_o | output | 1 | Ejected flit valid |
| ej_flit_o | output | ID_W+DATA_W | Ejected flit |

## Verification
The ring outputs, credit outputs and eject port are functions of registered state, plus the injection inputs in the same cycle. A flit driven on a ring input in cycle n is therefore due on an output in cycle n+1. A credit received in cycle n counts from cycle n+1, and an injection shows on its output in the cycle it is offered. The bench drives every input on the falling clock edge and samples all outputs one nanosecond later, before the next rising edge. This places each expected value in the exact cycle the rules above give. A per-cycle vector table covers forwarding, ejection, priority and credit stalls. Directed sequences then cover credit exhaustion, the ejection alternation and a streamed burst with a one-cycle credit loop.

// File: rtl/ring_rtr_pkg.sv
`timescale 1ns/1ps
package ring_rtr_pkg;
  typedef enum logic {DIR_RGT = 1'b0, DIR_LFT = 1'b1} inj_dir_e;
  // side index used for buffers (input) and credit counters (output)
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
endpackage

// File: rtl/ring_ibuf.sv
`timescale 1ns/1ps
module ring_ibuf #(
  parameter int W     = 11,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         vld_o,
  output logic [W-1:0] dout_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  assign vld_o  = (cnt_q != '0);
  assign dout_o = mem_q[rp_q];

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_W'(DEPTH)) || pop_i);
  // R1
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/ring_crd_cnt.sv
`timescale 1ns/1ps
module ring_crd_cnt #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic give_i,
  output logic has_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= CNT_W'(DEPTH);
    else if (take_i && !give_i)  cnt_q <= cnt_q - 1'b1;
    else if (give_i && !take_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign has_o = (cnt_q != '0);

  // R2
  crd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R2
  crd_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> cnt_q != '0);
  // R2
  crd_excess_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (give_i && !take_i) |-> cnt_q != CNT_W'(DEPTH));
endmodule

// File: rtl/ring_ej_arb.sv
`timescale 1ns/1ps
module ring_ej_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic prio_q; // 0: index 0 favoured

  assign gnt_o[0] = req_i[0] && (!req_i[1] || !prio_q);
  assign gnt_o[1] = req_i[1] && (!req_i[0] ||  prio_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prio_q <= 1'b0;
    else if (gnt_o[0]) prio_q <= 1'b1;
    else if (gnt_o[1]) prio_q <= 1'b0;
  end

  // R7
  ej_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R7
  ej_fair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == 2'b11 && gnt_o[0]) |=> (req_i != 2'b11 || gnt_o[1]));
endmodule

// File: rtl/ring_credit_router.sv
`timescale 1ns/1ps
module ring_credit_router
  import ring_rtr_pkg::*;
#(
  parameter int ID_W    = 3,
  parameter int DATA_W  = 8,
  parameter int NODE_ID = 2,
  parameter int DEPTH   = 2,
  localparam int FLIT_W = ID_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lft_in_vld_i,
  input  logic [FLIT_W-1:0] lft_in_flit_i,
  output logic              lft_crd_o,
  output logic              lft_out_vld_o,
  output logic [FLIT_W-1:0] lft_out_flit_o,
  input  logic              lft_crd_i,
  input  logic              rgt_in_vld_i,
  input  logic [FLIT_W-1:0] rgt_in_flit_i,
  output logic              rgt_crd_o,
  output logic              rgt_out_vld_o,
  output logic [FLIT_W-1:0] rgt_out_flit_o,
  input  logic              rgt_crd_i,
  input  logic              inj_vld_i,
  input  logic              inj_dir_i,
  input  logic [FLIT_W-1:0] inj_flit_i,
  output logic              inj_rdy_o,
  output logic              ej_vld_o,
  output logic [FLIT_W-1:0] ej_flit_o
);
  logic              in_vld   [2];
  logic [FLIT_W-1:0] in_flit  [2];
  logic              hd_vld   [2];
  logic [FLIT_W-1:0] hd_flit  [2];
  logic              pop      [2];
  logic              thru_req [2];
  logic              thru_go  [2];
  logic              out_vld  [2];
  logic [FLIT_W-1:0] out_flit [2];
  logic              crd_in   [2];
  logic              has_crd  [2];
  logic              inj_sel  [2];
  logic [1:0]        ej_req, ej_gnt;
  int unsigned       inj_out;

  assign in_vld[SIDE_L]  = lft_in_vld_i;
  assign in_flit[SIDE_L] = lft_in_flit_i;
  assign in_vld[SIDE_R]  = rgt_in_vld_i;
  assign in_flit[SIDE_R] = rgt_in_flit_i;
  assign crd_in[SIDE_L]  = lft_crd_i;
  assign crd_in[SIDE_R]  = rgt_crd_i;

  // input s feeds output 1-s; output o is fed by input 1-o
  assign inj_out   = (inj_dir_e'(inj_dir_i) == DIR_LFT) ? SIDE_L : SIDE_R;
  assign inj_rdy_o = has_crd[inj_out] && !thru_req[1 - inj_out];

  for (genvar s = 0; s < 2; s++) begin : g_side
    ring_ibuf #(.W(FLIT_W), .DEPTH(DEPTH)) u_ibuf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (in_vld[s]),
      .din_i  (in_flit[s]),
      .pop_i  (pop[s]),
      .vld_o  (hd_vld[s]),
      .dout_o (hd_flit[s])
    );

    ring_crd_cnt #(.DEPTH(DEPTH)) u_crd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (out_vld[s]),
      .give_i (crd_in[s]),
      .has_o  (has_crd[s])
    );

    assign ej_req[s]   = hd_vld[s] && (hd_flit[s][FLIT_W-1 -: ID_W] == ID_W'(NODE_ID));
    assign thru_req[s] = hd_vld[s] && !ej_req[s];
    assign thru_go[s]  = thru_req[s] && has_crd[1 - s];
    assign pop[s]      = thru_go[s] || ej_gnt[s];
    assign inj_sel[s]  = inj_vld_i && inj_rdy_o && (inj_out == s);
    assign out_vld[s]  = thru_go[1 - s] || inj_sel[s];
    assign out_flit[s] = thru_go[1 - s] ? hd_flit[1 - s] : inj_flit_i;
  end

  ring_ej_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (ej_req),
    .gnt_o  (ej_gnt)
  );

  assign ej_vld_o  = |ej_gnt;
  assign ej_flit_o = ej_gnt[SIDE_R] ? hd_flit[SIDE_R] : hd_flit[SIDE_L];

  assign lft_crd_o      = pop[SIDE_L];
  assign rgt_crd_o      = pop[SIDE_R];
  assign lft_out_vld_o  = out_vld[SIDE_L];
  assign lft_out_flit_o = out_flit[SIDE_L];
  assign rgt_out_vld_o  = out_vld[SIDE_R];
  assign rgt_out_flit_o = out_flit[SIDE_R];

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thru_req[SIDE_L] && !lft_crd_o) |=> (hd_vld[SIDE_L] && $stable(hd_flit[SIDE_L])));
  // R5
  inj_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_vld_i && inj_dir_i == DIR_RGT && thru_req[SIDE_L]) |-> !inj_rdy_o);
  // R4
  ej_no_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ej_gnt[SIDE_L]) |-> !(rgt_out_vld_o && rgt_out_flit_o == hd_flit[SIDE_L] && !inj_vld_i));
endmodule

// File: tb/test_ring_credit_router.sv
`timescale 1ns/1ps
module test_ring_credit_router;
  localparam int FW = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lft_in_vld_i = 0, rgt_in_vld_i = 0, inj_vld_i = 0, inj_dir_i = 0;
  logic [FW-1:0] lft_in_flit_i = '0, rgt_in_flit_i = '0, inj_flit_i = '0;
  logic          lft_crd_i = 0, rgt_crd_i = 0;
  logic          lft_crd_o, rgt_crd_o, lft_out_vld_o, rgt_out_vld_o, inj_rdy_o, ej_vld_o;
  logic [FW-1:0] lft_out_flit_o, rgt_out_flit_o, ej_flit_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ring_credit_router i_ring_credit_router (
    .clk_i(clk), .rst_ni(rst_ni),
    .lft_in_vld_i(lft_in_vld_i), .lft_in_flit_i(lft_in_flit_i), .lft_crd_o(lft_crd_o),
    .lft_out_vld_o(lft_out_vld_o), .lft_out_flit_o(lft_out_flit_o), .lft_crd_i(lft_crd_i),
    .rgt_in_vld_i(rgt_in_vld_i), .rgt_in_flit_i(rgt_in_flit_i), .rgt_crd_o(rgt_crd_o),
    .rgt_out_vld_o(rgt_out_vld_o), .rgt_out_flit_o(rgt_out_flit_o), .rgt_crd_i(rgt_crd_i),
    .inj_vld_i(inj_vld_i), .inj_dir_i(inj_dir_i), .inj_flit_i(inj_flit_i), .inj_rdy_o(inj_rdy_o),
    .ej_vld_o(ej_vld_o), .ej_flit_o(ej_flit_o)
  );

  typedef struct packed {
    logic lv; logic [FW-1:0] lf; logic rv; logic [FW-1:0] rf;
    logic iv; logic id; logic [FW-1:0] inf; logic lc; logic rc;
    logic e_lv; logic [FW-1:0] e_lf; logic e_rv; logic [FW-1:0] e_rf;
    logic e_ev; logic [FW-1:0] e_ef; logic e_rdy; logic e_lco; logic e_rco;
  } vec_t;

  // destination in bits [10:8], this node is 2
  localparam logic [FW-1:0] Z  = '0;
  localparam logic [FW-1:0] FA = {3'd5, 8'h11};
  localparam logic [FW-1:0] FB = {3'd7, 8'h22};
  localparam logic [FW-1:0] FC = {3'd2, 8'h33};
  localparam logic [FW-1:0] FD = {3'd2, 8'h44};
  localparam logic [FW-1:0] FE = {3'd0, 8'h55};
  localparam logic [FW-1:0] FF = {3'd6, 8'h66};
  localparam logic [FW-1:0] FG = {3'd4, 8'h77};
  localparam logic [FW-1:0] FH = {3'd1, 8'h88};

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    // R3 A enters left
    '{1'b1,FA,1'b0,Z, 1'b0,1'b0,Z, 1'b0,1'b0,  1'b0,Z, 1'b0,Z,  1'b0,Z,  1'b1,1'b0,1'b0},
    // R3 A out right one cycle later, R6 B injected left
    '{1'b0,Z, 1'b0,Z, 1'b1,1'b1,FB, 1'b0,1'b0, 1'b1,FB, 1'b1,FA, 1'b0,Z,  1'b1,1'b1,1'b0},
    // D left and C right, both for this node; credits returned
    '{1'b1,FD,1'b1,FC,1'b0,1'b0,Z, 1'b1,1'b1,  1'b0,Z, 1'b0,Z,  1'b0,Z,  1'b1,1'b0,1'b0},
    // R7 left wins first; R6 E injected right beside ejection
    '{1'b0,Z, 1'b0,Z, 1'b1,1'b0,FE, 1'b0,1'b0, 1'b0,Z, 1'b1,FE, 1'b1,FD, 1'b1,1'b1,1'b0},
    // R7 then right; R4 not forwarded
    '{1'b1,FF,1'b0,Z, 1'b0,1'b0,Z, 1'b0,1'b0,  1'b0,Z, 1'b0,Z,  1'b1,FC, 1'b1,1'b0,1'b1},
    // R5 F through, injection refused
    '{1'b0,Z, 1'b0,Z, 1'b1,1'b0,FG, 1'b0,1'b0, 1'b0,Z, 1'b1,FF, 1'b0,Z,  1'b0,1'b1,1'b0},
    // R2 right count zero, H enters
    '{1'b1,FH,1'b0,Z, 1'b1,1'b0,FG, 1'b0,1'b0, 1'b0,Z, 1'b0,Z,  1'b0,Z,  1'b0,1'b0,1'b0},
    // R8 H stalled, R5 refused; credit returns
    '{1'b0,Z, 1'b0,Z, 1'b1,1'b0,FG, 1'b0,1'b1, 1'b0,Z, 1'b0,Z,  1'b0,Z,  1'b0,1'b0,1'b0},
    // R8 H leaves
    '{1'b0,Z, 1'b0,Z, 1'b0,1'b0,Z, 1'b0,1'b0,  1'b0,Z, 1'b1,FH, 1'b0,Z,  1'b0,1'b1,1'b0},
    // R6 G goes left while right is out of credit
    '{1'b0,Z, 1'b0,Z, 1'b1,1'b1,FG, 1'b0,1'b1, 1'b1,FG, 1'b0,Z,  1'b0,Z,  1'b1,1'b0,1'b0},
    // idle, right count back to 1
    '{1'b0,Z, 1'b0,Z, 1'b0,1'b0,Z, 1'b0,1'b0,  1'b0,Z, 1'b0,Z,  1'b0,Z,  1'b1,1'b0,1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    lft_in_vld_i = 0; rgt_in_vld_i = 0; inj_vld_i = 0; inj_dir_i = 0;
    lft_in_flit_i = '0; rgt_in_flit_i = '0; inj_flit_i = '0;
    lft_crd_i = 0; rgt_crd_i = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(!lft_out_vld_o && !rgt_out_vld_o && !ej_vld_o, "R9 valids", {lft_out_vld_o, rgt_out_vld_o, ej_vld_o}, 0);
    chk(!lft_crd_o && !rgt_crd_o, "R9 credits", {lft_crd_o, rgt_crd_o}, 0);
    chk(inj_rdy_o, "R9 inj_rdy", inj_rdy_o, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // vector table, one cycle per entry
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      lft_in_vld_i = VEC[i].lv; lft_in_flit_i = VEC[i].lf;
      rgt_in_vld_i = VEC[i].rv; rgt_in_flit_i = VEC[i].rf;
      inj_vld_i = VEC[i].iv; inj_dir_i = VEC[i].id; inj_flit_i = VEC[i].inf;
      lft_crd_i = VEC[i].lc; rgt_crd_i = VEC[i].rc;
      #1;
      chk(lft_out_vld_o == VEC[i].e_lv, "R3/R6 lft_out_vld", lft_out_vld_o, VEC[i].e_lv);
      if (VEC[i].e_lv) chk(lft_out_flit_o == VEC[i].e_lf, "R3/R6 lft_out_flit", lft_out_flit_o, VEC[i].e_lf);
      chk(rgt_out_vld_o == VEC[i].e_rv, "R3/R8 rgt_out_vld", rgt_out_vld_o, VEC[i].e_rv);
      if (VEC[i].e_rv) chk(rgt_out_flit_o == VEC[i].e_rf, "R3/R8 rgt_out_flit", rgt_out_flit_o, VEC[i].e_rf);
      chk(ej_vld_o == VEC[i].e_ev, "R4 ej_vld", ej_vld_o, VEC[i].e_ev);
      if (VEC[i].e_ev) chk(ej_flit_o == VEC[i].e_ef, "R4/R7 ej_flit", ej_flit_o, VEC[i].e_ef);
      chk(inj_rdy_o == VEC[i].e_rdy, "R5/R6 inj_rdy", inj_rdy_o, VEC[i].e_rdy);
      chk(lft_crd_o == VEC[i].e_lco, "R1 lft_crd_o", lft_crd_o, VEC[i].e_lco);
      chk(rgt_crd_o == VEC[i].e_rco, "R1 rgt_crd_o", rgt_crd_o, VEC[i].e_rco);
    end

    // R2: credit exhaustion on right output and refill
    do_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle_inputs();
      inj_vld_i = 1; inj_dir_i = 0; inj_flit_i = {3'd6, 8'(8'hA0 + k)};
      #1;
      chk(inj_rdy_o == (k < 2), "R2 credit limit rdy", inj_rdy_o, (k < 2));
      chk(rgt_out_vld_o == (k < 2), "R2 credit limit vld", rgt_out_vld_o, (k < 2));
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      idle_inputs();
      rgt_crd_i = 1;
    end
    @(negedge clk);
    idle_inputs();
    inj_vld_i = 1; inj_dir_i = 0;
    #1;
    chk(inj_rdy_o, "R2 credit refilled", inj_rdy_o, 1);

    // R7: two ejecting flits from each side alternate L,R,L,R
    do_reset();
    @(negedge clk);
    idle_inputs();
    lft_in_vld_i = 1; lft_in_flit_i = {3'd2, 8'hB1};
    rgt_in_vld_i = 1; rgt_in_flit_i = {3'd2, 8'hC1};
    @(negedge clk);
    lft_in_flit_i = {3'd2, 8'hB2};
    rgt_in_flit_i = {3'd2, 8'hC2};
    #1;
    chk(ej_vld_o && ej_flit_o == {3'd2, 8'hB1}, "R7 first left", ej_flit_o, {3'd2, 8'hB1});
    @(negedge clk);
    idle_inputs();
    #1;
    chk(ej_vld_o && ej_flit_o == {3'd2, 8'hC1}, "R7 then right", ej_flit_o, {3'd2, 8'hC1});
    chk(rgt_crd_o && !lft_crd_o, "R1 credit side", {lft_crd_o, rgt_crd_o}, 2'b01);
    @(negedge clk);
    #1;
    chk(ej_vld_o && ej_flit_o == {3'd2, 8'hB2}, "R7 left again", ej_flit_o, {3'd2, 8'hB2});
    @(negedge clk);
    #1;
    chk(ej_vld_o && ej_flit_o == {3'd2, 8'hC2}, "R7 right again", ej_flit_o, {3'd2, 8'hC2});
    chk(!rgt_out_vld_o && !lft_out_vld_o, "R4 no forward", {lft_out_vld_o, rgt_out_vld_o}, 0);

    // R8: streamed burst, credit returned one cycle after receipt
    do_reset();
    begin
      int up_cnt = 2, sent = 0, got = 0, first_at = -1;
      logic ret_next = 0;
      for (int cyc = 0; cyc < 20; cyc++) begin
        @(negedge clk);
        idle_inputs();
        lft_in_vld_i  = (up_cnt > 0) && (sent < 8);
        lft_in_flit_i = {3'd5, 8'(8'h40 + sent)};
        rgt_crd_i     = ret_next;
        #1;
        if (rgt_out_vld_o) begin
          chk(rgt_out_flit_o == {3'd5, 8'(8'h40 + got)}, "R8 order", rgt_out_flit_o, {3'd5, 8'(8'h40 + got)});
          if (got == 0) first_at = cyc;
          got++;
        end
        ret_next = rgt_out_vld_o;
        if (lft_in_vld_i) begin up_cnt--; sent++; end
        if (lft_crd_o) up_cnt++;
      end
      chk(got == 8, "R8 no loss or duplicate", got, 8);
      chk(first_at == 1, "R3 one cycle per hop", first_at, 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule